// File: doc/BRIEF.md
# Look-Ahead Grant Predictor with Collision Abort

This block is the scheduling core of a router that moves a flit through its switch in the same cycle the flit arrives. Each output resource (a physical link or a virtual channel on it) has a set of registered grant-enable bits, one per input. The enables are computed one cycle early. Early in the following cycle, each input's request is ANDed with its enable to form a grant, so no arbitration sits on the datapath's critical path. Every flit carries, as a binary index, the resource it needs at this router. That index was worked out by the router upstream, so the block evaluates no routing function.

If some inputs are known to want a resource next cycle, a round-robin pick sets exactly one enable for it. If nobody is known to want it, the block assumes that at most one new flit will turn up and sets every enable of that resource. When two or more newly arrived flits then hit such a resource together, a pairwise comparator network over the new flits spots the collision. The block withholds the resource for that cycle and raises its abort bit. The colliding flits are buffered and take part in the next cycle's schedule, which is then non-speculative.

The next-request set always holds every buffered head flit, including a head that is being held back. Parameter `NEXT_MODE` chooses the rest of the set. The accurate variant adds the new flits that were not granted. The simplified variant adds every current request. A head flit exposed by a departing tail is held for one cycle and makes no request during that cycle.

Top module: `gnt_predict`

## Requirements
- R1: A grant is given only to an input whose current request names that resource and whose registered enable for it is set. No resource is granted to more than one input in a cycle.
- R2: When the next-request set for a resource is non-empty, the enable of exactly one input is set for the next cycle. That input is the first requester found scanning upward (with wrap) from the resource's round-robin pointer. The pointer then moves to the input just after the winner.
- R3: When the next-request set for a resource is empty, every enable of that resource is set. The resource is speculative next cycle, and a single new flit that asks for it is granted at once.
- R4: A speculative resource that two or more newly arrived flits request in one cycle is aborted. Its bit in `abort_o` is high, and that resource grants nothing in that cycle.
- R5: In the cycle after an abort, the aborted resource is non-speculative, and one of the colliding flits (now buffered) is granted in that cycle.
- R6: An input whose buffered head has `hold_i` set makes no request and receives no grant in that cycle. The held head is included in the next-request set.
- R7: A new flit that arrives at an input whose buffer is occupied makes no request and takes no part in abort detection. The request of that input comes from its buffered head.
- R8: The next-request set contains every buffered head. With `NEXT_MODE` accurate it also contains the new flits that were not granted this cycle. With `NEXT_MODE` simplified it also contains every current request.
- R9: After reset, every resource is speculative and every round-robin pointer is 0.
- R10: Resource indices are binary. Input i uses bits [i*W +: W] of `buf_res_i` and `new_res_i`, where W = max(1, clog2(NUM_RES)). Bit i of `grant_o` belongs to input i, and bit r of `abort_o` belongs to resource r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_vld_i | input | NUM_IN | Input buffer holds a head flit |
| buf_res_i | input | NUM_IN*W | Resource index of each buffered head |
| hold_i | input | NUM_IN | Buffered head was just exposed and must wait one cycle |
| new_vld_i | input | NUM_IN | A flit arrives at the input this cycle |
| new_res_i | input | NUM_IN*W | Resource index of each arriving flit |
| grant_o | output | NUM_IN | The input's request is granted this cycle |
| abort_o | output | NUM_RES | A speculative resource had a collision this cycle |

## Verification
The bench targets the collision cases. Two new flits meet on a speculative resource. A design that compared the wrong pairs, or ignored the speculative flag, would either grant both flits or block a resource that had been scheduled properly. It checks that the aborted flits are resolved in the following cycle and that round-robin order holds across back-to-back scheduled cycles. A pointer that moved wrongly would show up as a grant to the wrong input. It also drives a held head and a new flit that lands on an occupied input. A design that let either of these request would give a double grant or a false abort. A long legal random run checks, every cycle, that no resource has two owners and that every abort comes with a real collision.

// File: rtl/gep_pkg.sv
package gep_pkg;

   typedef enum logic {
      NEXT_ALL_CUR   = 1'b0,
      NEXT_ACCURATE  = 1'b1
   } next_mode_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/gnt_req_decode.sv
module gnt_req_decode #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_RES = 4,
   parameter int unsigned RES_W   = 2
) (
   input  logic [NUM_IN-1:0]               buf_vld_i,
   input  logic [NUM_IN*RES_W-1:0]         buf_res_i,
   input  logic [NUM_IN-1:0]               hold_i,
   input  logic [NUM_IN-1:0]               new_vld_i,
   input  logic [NUM_IN*RES_W-1:0]         new_res_i,
   output logic [NUM_RES-1:0][NUM_IN-1:0]  req_mat_o,
   output logic [NUM_RES-1:0][NUM_IN-1:0]  new_mat_o,
   output logic [NUM_RES-1:0][NUM_IN-1:0]  buf_mat_o,
   output logic [NUM_IN-1:0]               new_ok_o
);

   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      logic             from_buf;
      logic             from_new;
      logic [RES_W-1:0] b_res;
      logic [RES_W-1:0] n_res;
      logic [RES_W-1:0] c_res;

      assign b_res    = buf_res_i[i*RES_W +: RES_W];
      assign n_res    = new_res_i[i*RES_W +: RES_W];
      assign from_buf = buf_vld_i[i] & ~hold_i[i];
      assign from_new = ~buf_vld_i[i] & new_vld_i[i];
      assign c_res    = buf_vld_i[i] ? b_res : n_res;
      assign new_ok_o[i] = from_new;

      for (genvar r = 0; r < NUM_RES; r++) begin : g_res
         assign req_mat_o[r][i] = (from_buf | from_new) && (c_res == RES_W'(r));
         assign new_mat_o[r][i] = from_new && (n_res == RES_W'(r));
         assign buf_mat_o[r][i] = buf_vld_i[i] && (b_res == RES_W'(r));
      end
   end

endmodule

// File: rtl/gnt_abort_net.sv
module gnt_abort_net #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_RES = 4,
   parameter int unsigned RES_W   = 2
) (
   input  logic [NUM_IN-1:0]        new_ok_i,
   input  logic [NUM_IN*RES_W-1:0]  new_res_i,
   input  logic [NUM_RES-1:0]       spec_q_i,
   output logic [NUM_RES-1:0]       abort_o
);

   localparam int unsigned NUM_PAIRS = NUM_IN * (NUM_IN - 1) / 2;

   logic [NUM_PAIRS-1:0]            pair_hit;
   logic [NUM_PAIRS-1:0][RES_W-1:0] pair_res;
   logic [NUM_RES-1:0]              collide;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_a
      for (genvar j = i + 1; j < NUM_IN; j++) begin : g_b
         localparam int unsigned K = i * NUM_IN - (i * (i + 1)) / 2 + (j - i - 1);
         assign pair_hit[K] = new_ok_i[i] & new_ok_i[j] &
                              (new_res_i[i*RES_W +: RES_W] == new_res_i[j*RES_W +: RES_W]);
         assign pair_res[K] = new_res_i[i*RES_W +: RES_W];
      end
   end

   always_comb begin
      collide = '0;
      for (int k = 0; k < NUM_PAIRS; k++) begin
         for (int r = 0; r < NUM_RES; r++) begin
            if (pair_hit[k] && (pair_res[k] == RES_W'(r))) collide[r] = 1'b1;
         end
      end
   end

   assign abort_o = collide & spec_q_i;

endmodule

// File: rtl/gnt_next_set.sv
module gnt_next_set #(
   parameter int unsigned          NUM_IN    = 4,
   parameter int unsigned          NUM_RES   = 4,
   parameter gep_pkg::next_mode_e  NEXT_MODE = gep_pkg::NEXT_ACCURATE
) (
   input  logic [NUM_RES-1:0][NUM_IN-1:0] buf_mat_i,
   input  logic [NUM_RES-1:0][NUM_IN-1:0] req_mat_i,
   input  logic [NUM_RES-1:0][NUM_IN-1:0] new_mat_i,
   input  logic [NUM_RES-1:0][NUM_IN-1:0] grant_mat_i,
   output logic [NUM_RES-1:0][NUM_IN-1:0] nxt_mat_o
);

   logic [NUM_RES-1:0][NUM_IN-1:0] keep;

   if (NEXT_MODE == gep_pkg::NEXT_ACCURATE) begin : g_accurate
      assign keep = ~(new_mat_i & grant_mat_i);
   end else begin : g_all_cur
      assign keep = '1;
   end

   assign nxt_mat_o = buf_mat_i | (req_mat_i & keep);

endmodule

// File: rtl/gnt_rr_sched.sv
module gnt_rr_sched #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_RES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_RES-1:0][NUM_IN-1:0] nxt_mat_i,
   output logic [NUM_RES-1:0][NUM_IN-1:0] en_q_o,
   output logic [NUM_RES-1:0]            spec_q_o
);

   localparam int unsigned IDX_W = gep_pkg::idx_w(NUM_IN);

   for (genvar r = 0; r < NUM_RES; r++) begin : g_res
      logic [IDX_W-1:0]  ptr_q;
      logic [IDX_W-1:0]  ptr_d;
      logic [NUM_IN-1:0] upper;
      logic [NUM_IN-1:0] pick;
      logic [IDX_W-1:0]  win;
      logic [NUM_IN-1:0] cand;

      always_comb begin
         for (int k = 0; k < NUM_IN; k++) upper[k] = (IDX_W'(k) >= ptr_q);
         cand = ((nxt_mat_i[r] & upper) != '0) ? (nxt_mat_i[r] & upper) : nxt_mat_i[r];
         pick = cand & (~cand + NUM_IN'(1));
         win  = '0;
         for (int k = 0; k < NUM_IN; k++) begin
            if (pick[k]) win = IDX_W'(k);
         end
         ptr_d = (win == IDX_W'(NUM_IN - 1)) ? '0 : win + IDX_W'(1);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q_o[r]   <= '1;
            spec_q_o[r] <= 1'b1;
            ptr_q       <= '0;
         end else if (nxt_mat_i[r] != '0) begin
            en_q_o[r]   <= pick;
            spec_q_o[r] <= 1'b0;
            ptr_q       <= ptr_d;
         end else begin
            en_q_o[r]   <= '1;
            spec_q_o[r] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/gnt_predict.sv
module gnt_predict #(
   parameter int unsigned          NUM_IN    = 4,
   parameter int unsigned          NUM_RES   = 4,
   parameter gep_pkg::next_mode_e  NEXT_MODE = gep_pkg::NEXT_ACCURATE,
   parameter int unsigned          RES_W     = gep_pkg::idx_w(NUM_RES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IN-1:0]         buf_vld_i,
   input  logic [NUM_IN*RES_W-1:0]   buf_res_i,
   input  logic [NUM_IN-1:0]         hold_i,
   input  logic [NUM_IN-1:0]         new_vld_i,
   input  logic [NUM_IN*RES_W-1:0]   new_res_i,
   output logic [NUM_IN-1:0]         grant_o,
   output logic [NUM_RES-1:0]        abort_o
);

   if (NUM_IN < 2) begin : g_bad_in
      $error("gnt_predict: NUM_IN must be at least 2");
   end
   if (NUM_RES < 1) begin : g_bad_res
      $error("gnt_predict: NUM_RES must be at least 1");
   end
   if (RES_W < gep_pkg::idx_w(NUM_RES)) begin : g_bad_w
      $error("gnt_predict: RES_W too narrow for NUM_RES");
   end

   logic [NUM_RES-1:0][NUM_IN-1:0] req_mat;
   logic [NUM_RES-1:0][NUM_IN-1:0] new_mat;
   logic [NUM_RES-1:0][NUM_IN-1:0] buf_mat;
   logic [NUM_RES-1:0][NUM_IN-1:0] grant_mat;
   logic [NUM_RES-1:0][NUM_IN-1:0] nxt_mat;
   logic [NUM_RES-1:0][NUM_IN-1:0] en_q;
   logic [NUM_RES-1:0]             spec_q;
   logic [NUM_IN-1:0]              new_ok;

   gnt_req_decode #(.NUM_IN(NUM_IN), .NUM_RES(NUM_RES), .RES_W(RES_W)) u_dec (
      .buf_vld_i (buf_vld_i),
      .buf_res_i (buf_res_i),
      .hold_i    (hold_i),
      .new_vld_i (new_vld_i),
      .new_res_i (new_res_i),
      .req_mat_o (req_mat),
      .new_mat_o (new_mat),
      .buf_mat_o (buf_mat),
      .new_ok_o  (new_ok)
   );

   gnt_abort_net #(.NUM_IN(NUM_IN), .NUM_RES(NUM_RES), .RES_W(RES_W)) u_abort (
      .new_ok_i  (new_ok),
      .new_res_i (new_res_i),
      .spec_q_i  (spec_q),
      .abort_o   (abort_o)
   );

   for (genvar r = 0; r < NUM_RES; r++) begin : g_gnt
      assign grant_mat[r] = req_mat[r] & en_q[r] & {NUM_IN{~abort_o[r]}};
   end

   always_comb begin
      grant_o = '0;
      for (int r = 0; r < NUM_RES; r++) grant_o |= grant_mat[r];
   end

   gnt_next_set #(.NUM_IN(NUM_IN), .NUM_RES(NUM_RES), .NEXT_MODE(NEXT_MODE)) u_next (
      .buf_mat_i   (buf_mat),
      .req_mat_i   (req_mat),
      .new_mat_i   (new_mat),
      .grant_mat_i (grant_mat),
      .nxt_mat_o   (nxt_mat)
   );

   gnt_rr_sched #(.NUM_IN(NUM_IN), .NUM_RES(NUM_RES)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_mat_i (nxt_mat),
      .en_q_o    (en_q),
      .spec_q_o  (spec_q)
   );

endmodule

// File: rtl/gnt_predict_chk.sv
module gnt_predict_chk #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_RES = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_RES-1:0][NUM_IN-1:0] grant_mat,
   input logic [NUM_RES-1:0][NUM_IN-1:0] en_q,
   input logic [NUM_RES-1:0]            spec_q,
   input logic [NUM_RES-1:0]            abort_o,
   input logic [NUM_IN-1:0]             grant_o,
   input logic [NUM_IN-1:0]             hold_i,
   input logic [NUM_IN-1:0]             buf_vld_i
);

   for (genvar r = 0; r < NUM_RES; r++) begin : g_r
      // R1
      one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(grant_mat[r]));
      // R4
      abort_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         abort_o[r] |-> (grant_mat[r] == '0));
      // R5
      abort_resched_chk: assert property (@(posedge clk) disable iff (!rst_n)
         abort_o[r] |=> !spec_q[r]);
      // R2
      sched_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !spec_q[r] |-> ($countones(en_q[r]) == 1));
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_i
      // R6
      held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (buf_vld_i[i] && hold_i[i]) |-> !grant_o[i]);
   end

endmodule

bind gnt_predict gnt_predict_chk #(.NUM_IN(NUM_IN), .NUM_RES(NUM_RES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant_mat (grant_mat),
   .en_q      (en_q),
   .spec_q    (spec_q),
   .abort_o   (abort_o),
   .grant_o   (grant_o),
   .hold_i    (hold_i),
   .buf_vld_i (buf_vld_i)
);

// File: tb/gnt_predict_tb_top.sv
module gnt_predict_tb_top;

   localparam int P = 4;
   localparam int R = 4;
   localparam int W = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [P-1:0] buf_vld = '0;
   logic [P*W-1:0] buf_res = '0;
   logic [P-1:0] hold = '0;
   logic [P-1:0] new_vld = '0;
   logic [P*W-1:0] new_res = '0;
   logic [P-1:0] grant;
   logic [R-1:0] abort;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   gnt_predict #(.NUM_IN(P), .NUM_RES(R)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_vld_i (buf_vld),
      .buf_res_i (buf_res),
      .hold_i    (hold),
      .new_vld_i (new_vld),
      .new_res_i (new_res),
      .grant_o   (grant),
      .abort_o   (abort)
   );

   // row: {buf_vld, buf_res, hold, new_vld, new_res, exp_grant, exp_abort}
   localparam logic [35:0] TBL [8] = '{
      {4'b0000, 8'h00, 4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0000},
      {4'b0000, 8'h00, 4'b0000, 4'b0011, 8'h09, 4'b0011, 4'b0000},
      {4'b0000, 8'h00, 4'b0000, 4'b1101, 8'h33, 4'b1000, 4'b1000},
      {4'b0101, 8'h33, 4'b0000, 4'b0010, 8'h0C, 4'b0001, 4'b0000},
      {4'b0110, 8'h3C, 4'b0000, 4'b0000, 8'h00, 4'b0010, 4'b0000},
      {4'b0110, 8'h30, 4'b0010, 4'b1000, 8'h00, 4'b1100, 4'b0000},
      {4'b0010, 8'h00, 4'b0000, 4'b1000, 8'h00, 4'b0010, 4'b0000},
      {4'b1000, 8'h00, 4'b0000, 4'b0111, 8'h2F, 4'b1100, 4'b1000}
   };

   localparam string TAGS [8] = '{
      "R9 idle", "R3 lone new", "R4 collide", "R5 R2 resched",
      "R2 rr next", "R6 held head", "R2 R1 sched", "R4 R3 mixed"
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] bv, input logic [7:0] br, input logic [3:0] hd,
                        input logic [3:0] nv, input logic [7:0] nr);
      @(negedge clk);
      buf_vld = bv; buf_res = br; hold = hd; new_vld = nv; new_res = nr;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      buf_vld = '0; hold = '0; new_vld = '0; buf_res = '0; new_res = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic       occ   [P];
      logic       held  [P];
      logic [1:0] hres  [P];
      logic [3:0] bv, hd, nv;
      logic [7:0] br, nr;
      int         cnt;
      int         ncnt;

      do_reset();

      // R9: reset leaves no grant and no abort without requests
      drive(4'b0000, 8'h00, 4'b0000, 4'b0000, 8'h00);
      chk(grant == 4'b0000 && abort == 4'b0000, "R9 reset outputs", {grant, abort}, 0);

      // table walk, R10 encodings
      for (int k = 0; k < 8; k++) begin
         drive(TBL[k][35:32], TBL[k][31:24], TBL[k][23:20], TBL[k][19:16], TBL[k][15:8]);
         chk(grant == TBL[k][7:4], {TAGS[k], " grant"}, grant, TBL[k][7:4]);
         chk(abort == TBL[k][3:0], {TAGS[k], " abort"}, abort, TBL[k][3:0]);
      end

      // directed corner cases after a fresh reset
      do_reset();
      // R7: in2 buffered (res3) and also gets a new flit to res1; in3 new to res1
      drive(4'b0100, 8'h30, 4'b0000, 4'b1100, 8'h50);
      chk(grant == 4'b1100, "R7 occupied input ignores new", grant, 4'b1100);
      chk(abort == 4'b0000, "R7 no false abort", abort, 0);
      // R9 R4: res1 speculative after reset, two new flits collide
      drive(4'b0000, 8'h00, 4'b0000, 4'b0011, 8'h05);
      chk(abort == 4'b0010, "R4 abort res1", abort, 4'b0010);
      chk(grant == 4'b0000, "R4 no grant on abort", grant, 0);
      // R5: colliders now buffered, pointer 0 picks input 0
      drive(4'b0011, 8'h05, 4'b0000, 4'b0000, 8'h00);
      chk(grant == 4'b0001, "R5 resolve after abort", grant, 4'b0001);
      // R2 R8: input 1 still buffered, pointer moved past input 0
      drive(4'b0010, 8'h05, 4'b0000, 4'b0000, 8'h00);
      chk(grant == 4'b0010, "R2 round robin next", grant, 4'b0010);

      // legal random traffic, R1 R4 R6 R7 invariants
      do_reset();
      for (int i = 0; i < P; i++) begin occ[i] = 0; held[i] = 0; hres[i] = 0; end
      for (int c = 0; c < 4000; c++) begin
         bv = '0; hd = '0; nv = '0; br = '0; nr = '0;
         for (int i = 0; i < P; i++) begin
            bv[i] = occ[i];
            hd[i] = occ[i] & held[i];
            br[i*W +: W] = hres[i];
            nv[i] = ($urandom % 3) == 0;
            nr[i*W +: W] = 2'($urandom % R);
         end
         drive(bv, br, hd, nv, nr);
         for (int r = 0; r < R; r++) begin
            cnt = 0; ncnt = 0;
            for (int i = 0; i < P; i++) begin
               if (grant[i] && ((bv[i] ? br[i*W +: W] : nr[i*W +: W]) == 2'(r))) cnt++;
               if (!bv[i] && nv[i] && nr[i*W +: W] == 2'(r)) ncnt++;
            end
            chk(cnt <= 1, "R1 single owner", cnt, 1);
            if (abort[r]) begin
               chk(ncnt >= 2, "R4 abort needs collision", ncnt, 2);
               chk(cnt == 0, "R4 aborted resource idle", cnt, 0);
            end
         end
         for (int i = 0; i < P; i++) begin
            if (grant[i]) chk(bv[i] ? !hd[i] : nv[i], "R1 R6 grant needs request", grant[i], 0);
         end
         // buffer model update for the next cycle
         for (int i = 0; i < P; i++) begin
            if (occ[i] && held[i]) begin
               held[i] = 0;
            end else if (occ[i] && grant[i]) begin
               case ($urandom % 4)
                  0: occ[i] = 0;
                  3: begin hres[i] = 2'($urandom % R); held[i] = 1; end
                  default: ;
               endcase
            end else if (!occ[i] && nv[i] && !grant[i]) begin
               occ[i] = 1; hres[i] = nr[i*W +: W]; held[i] = 0;
            end
         end
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule